// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Timeout

This peripheral watches for a stalled processor. A free-running interval counter times a power-of-two window chosen by a 2-bit select field. When the window runs out, a timeout flag is raised, and it can drive an interrupt. If watchdog resets are enabled, the same event starts a second, fixed-length countdown. When that countdown ends, the block sends a one-clock reset request to the chip's reset generator. Software prevents both stages by writing the restart bit before the window ends.

The processor sees one 8-bit control/status register. A write takes effect at the clock edge on which `wr_en` is high. The read value is always shown on `rd_data`. Two reset inputs are provided. The power-on reset clears everything and marks the power-on cause. The system reset, which the reset request normally triggers, keeps the enables and both cause flags. Software can therefore tell after restart whether the watchdog fired.

Register layout used throughout: bit 7 power-on flag, bit 6 interrupt enable, bits 5:4 interval select, bit 3 timeout flag, bit 2 watchdog-reset flag, bit 1 reset enable, bit 0 restart.

Top module: `wdog_delayed_reset`

## Requirements
- R1: With the counter cleared at a clock edge, the timeout flag (bit 3) rises exactly 2^(BASE_EXP+STEP*code) clocks later. Here code is the select field (bits 5:4), and the defaults give 2^12, 2^15, 2^18 and 2^21 for codes 00, 01, 10 and 11.
- R2: `irq` is 1 exactly when the timeout flag and the interrupt enable (bit 6) are both 1. With the interrupt enable at 0, the counter keeps running and resets are still requested.
- R3: With reset enable (bit 1) at 1, `rst_req` goes high exactly RST_DLY (default 512) clocks after the timeout flag is set. It stays high for a single clock, and the watchdog-reset flag (bit 2) reads 1 from that same clock on.
- R4: Writing 1 to the timeout flag sets it and, when reset enable is 1, starts the same RST_DLY countdown.
- R5: With both enables at 0, the timer is stopped and the timeout flag never sets by itself. A write that sets either enable from this stopped state clears the interval count.
- R6: A write that changes the select field clears the interval count, unless the reset countdown is running. In that case neither counter is affected.
- R7: Writing 1 to the restart bit (bit 0) clears the interval count. Bit 0 always reads 0.
- R8: Writing 1 to the watchdog-reset flag sets it without requesting a reset. A timeout with reset enable at 0 leaves that flag at 0.
- R9: During a running countdown, a write that clears reset enable, or that sets the restart bit, cancels the pending reset request.
- R10: After power-on reset the register reads 8'h80: power-on flag 1, all other bits 0.
- R11: System reset clears the select field, the timeout flag and both counters. It keeps the power-on flag, both enables and the watchdog-reset flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-clock system reset request |

## Verification
A wrong interval count or a wrong select decode shows up as a timeout flag that rises one or more clocks early or late. The bench samples the flag one clock before and exactly at the required edge, so an off-by-one error is caught within a single window. A wrong countdown state shows up as `rst_req` at the wrong clock, lasting more than one clock, or appearing after a cancel. Pulses are counted over windows longer than RST_DLY, so a countdown that was not cancelled shows up within about 600 clocks. Wrong reset retention appears in the first register read after each reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int SEL_W = 2;
   localparam int NSEL  = 1 << SEL_W;

   // Field order is the register bit order, msb first.
   typedef struct packed {
      logic             pwr_flag;   // [7]
      logic             irq_en;     // [6]
      logic [SEL_W-1:0] sel;        // [5:4]
      logic             tmo_flag;   // [3]
      logic             wdr_flag;   // [2]
      logic             rst_en;     // [1]
      logic             kick;       // [0]
   } ctl_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       sys_rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       elapse,
   input  logic       fire,
   input  logic       cd_active,
   output ctl_t       ctl,
   output logic       clr_int,
   output logic       cd_start,
   output logic       cd_cancel
);

   ctl_t wr;
   logic was_stopped;
   logic wake;
   logic sel_chg;
   logic set_evt;
   logic rst_en_nx;

   assign wr          = ctl_t'(wr_data);
   assign was_stopped = !(ctl.irq_en || ctl.rst_en);
   assign wake        = wr_en && was_stopped && (wr.irq_en || wr.rst_en);
   assign sel_chg     = wr_en && (wr.sel != ctl.sel) && !cd_active;
   assign clr_int     = (wr_en && wr.kick) || sel_chg || wake;

   assign set_evt     = elapse || (wr_en && wr.tmo_flag);
   assign rst_en_nx   = wr_en ? wr.rst_en : ctl.rst_en;
   assign cd_start    = set_evt && rst_en_nx && !cd_active;
   assign cd_cancel   = cd_active && wr_en && (!wr.rst_en || wr.kick);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ctl          <= '0;
         ctl.pwr_flag <= 1'b1;
      end else if (!sys_rst_n) begin
         ctl.sel      <= '0;
         ctl.tmo_flag <= 1'b0;
         ctl.kick     <= 1'b0;
      end else begin
         if (wr_en) begin
            ctl.pwr_flag <= wr.pwr_flag;
            ctl.irq_en   <= wr.irq_en;
            ctl.sel      <= wr.sel;
            ctl.tmo_flag <= wr.tmo_flag;
            ctl.wdr_flag <= wr.wdr_flag;
            ctl.rst_en   <= wr.rst_en;
         end
         if (elapse) ctl.tmo_flag <= 1'b1;
         if (fire)   ctl.wdr_flag <= 1'b1;
         ctl.kick <= 1'b0;
      end
   end

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
   parameter int BASE_EXP = 12,
   parameter int STEP     = 3,
   parameter int NSEL     = 4,
   parameter int SEL_W    = 2,
   parameter int CNT_W    = BASE_EXP + (NSEL - 1) * STEP
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             sys_rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             elapse
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term [NSEL];

   generate
      if (BASE_EXP < 1 || STEP < 1 || CNT_W > 62) begin : g_bad_cfg
         $error("wdog_interval: unsupported exponent settings");
      end
      for (genvar i = 0; i < NSEL; i++) begin : g_term
         assign term[i] = CNT_W'((64'd1 << (BASE_EXP + i * STEP)) - 64'd1);
      end
   endgenerate

   assign elapse = run && !clr && (cnt == term[sel]);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  cnt <= '0;
      else if (!sys_rst_n || clr)  cnt <= '0;
      else if (elapse)             cnt <= '0;
      else if (run)                cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/wdog_rstdly.sv
module wdog_rstdly #(
   parameter int RST_DLY = 512,
   parameter int RCNT_W  = $clog2(RST_DLY)
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst_n,
   input  logic start,
   input  logic cancel,
   output logic active,
   output logic fire,
   output logic rst_req
);

   logic [RCNT_W-1:0] rcnt;

   generate
      if (RST_DLY < 2) begin : g_bad_dly
         $error("wdog_rstdly: RST_DLY must be at least 2");
      end
   endgenerate

   assign fire = active && !cancel && (rcnt == RCNT_W'(RST_DLY - 1));

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         active  <= 1'b0;
         rcnt    <= '0;
         rst_req <= 1'b0;
      end else if (!sys_rst_n) begin
         active  <= 1'b0;
         rcnt    <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fire;
         if (cancel || fire) begin
            active <= 1'b0;
            rcnt   <= '0;
         end else if (start) begin
            active <= 1'b1;
            rcnt   <= '0;
         end else if (active) begin
            rcnt   <= rcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_delayed_reset.sv
module wdog_delayed_reset #(
   parameter int BASE_EXP = 12,
   parameter int STEP     = 3,
   parameter int RST_DLY  = 512
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       sys_rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       irq,
   output logic       rst_req
);

   import wdog_pkg::*;

   localparam int CNT_W = BASE_EXP + (NSEL - 1) * STEP;

   ctl_t ctl;
   logic clr_int, cd_start, cd_cancel;
   logic elapse, fire, cd_active;

   wdog_regs u_regs (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .elapse    (elapse),
      .fire      (fire),
      .cd_active (cd_active),
      .ctl       (ctl),
      .clr_int   (clr_int),
      .cd_start  (cd_start),
      .cd_cancel (cd_cancel)
   );

   wdog_interval #(
      .BASE_EXP (BASE_EXP),
      .STEP     (STEP),
      .NSEL     (NSEL),
      .SEL_W    (SEL_W),
      .CNT_W    (CNT_W)
   ) u_interval (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .run       (ctl.irq_en || ctl.rst_en),
      .clr       (clr_int),
      .sel       (ctl.sel),
      .elapse    (elapse)
   );

   wdog_rstdly #(
      .RST_DLY (RST_DLY)
   ) u_rstdly (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .start     (cd_start),
      .cancel    (cd_cancel),
      .active    (cd_active),
      .fire      (fire),
      .rst_req   (rst_req)
   );

   assign rd_data = ctl;
   assign irq     = ctl.tmo_flag && ctl.irq_en;

endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
   input logic       clk,
   input logic       por_n,
   input logic       sys_rst_n,
   input logic       wr_en,
   input logic [7:0] rd_data,
   input logic       irq,
   input logic       rst_req
);

   // R3
   rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      rst_req |=> !rst_req);

   // R3
   rst_flags_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      rst_req |-> rd_data[2]);

   // R9
   rst_needs_enable_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      rst_req |-> $past(rd_data[1]));

   // R7
   kick_reads_zero_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      !rd_data[0]);

   // R5
   stopped_no_timeout_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      (!rd_data[6] && !rd_data[1] && !wr_en) |=> !$rose(rd_data[3]));

   // R2
   irq_gated_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
      irq |-> (rd_data[3] && rd_data[6]));

endmodule

bind wdog_delayed_reset wdog_chk u_chk (.*);

// File: tb/wdog_delayed_reset_tb.sv
module wdog_delayed_reset_tb;

   localparam int BASE_EXP = 6;
   localparam int STEP     = 3;
   localparam int RST_DLY  = 512;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_rst_n = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq, rst_req;

   int nchk = 0, nfail = 0, npulse = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_delayed_reset #(.BASE_EXP(BASE_EXP), .STEP(STEP), .RST_DLY(RST_DLY)) u_dut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .rst_req(rst_req));

   always @(posedge clk) if (rst_req) npulse++;

   typedef struct packed {
      logic [1:0] sel;
      logic       ien;
      logic       hit;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{2'd0, 1'b1, 1'b1},
      '{2'd1, 1'b1, 1'b1},
      '{2'd2, 1'b0, 1'b0},
      '{2'd3, 1'b1, 1'b1},
      '{2'd2, 1'b1, 1'b1}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a negedge; write lands on the next posedge.
   task automatic wr(logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int base;
      wait_n(3);
      por_n = 1'b1;
      wait_n(1);
      check("R10 por value", rd_data, 8'h80);
      check("R10 irq idle", irq, 1'b0);
      wr(8'h00);

      // Interval table walk (R1, R2, R5)
      for (int i = 0; i < 5; i++) begin
         int lim;
         lim = 1 << (BASE_EXP + STEP * VECS[i].sel);
         wr({1'b0, VECS[i].ien, VECS[i].sel, 4'b0001});
         wait_n(lim - 1);
         check("R1 flag before window", rd_data[3], 1'b0);
         wait_n(1);
         check("R1/R5 flag at window", rd_data[3], VECS[i].hit);
         check("R2 irq at window", irq, VECS[i].hit);
         wr(8'h00);
      end
      check("R8 no wdr flag without reset enable", rd_data[2], 1'b0);
      check("R3 no pulse without reset enable", npulse, 0);

      // R3 timeout-driven reset, interrupt disabled (R2)
      wr(8'h02);
      wait_n(63);
      check("R1 flag before window", rd_data[3], 1'b0);
      wait_n(1);
      check("R2 flag set", rd_data[3], 1'b1);
      check("R2 irq masked", irq, 1'b0);
      wait_n(511);
      check("R3 rst_req early", rst_req, 1'b0);
      wait_n(1);
      check("R3 rst_req on time", rst_req, 1'b1);
      check("R3 wdr flag", rd_data[2], 1'b1);
      wait_n(1);
      check("R3 single pulse", rst_req, 1'b0);

      // R11 system reset retention
      wr(8'h1E);
      sys_rst_n = 1'b0;
      wait_n(1);
      sys_rst_n = 1'b1;
      check("R11 after system reset", rd_data, 8'h06);
      wait_n(63);
      check("R11 counter cleared, before window", rd_data[3], 1'b0);
      wait_n(1);
      check("R11 counter cleared, at window", rd_data[3], 1'b1);
      wr(8'h00);

      // R8 software wdr flag write
      base = npulse;
      wr(8'h04);
      wait_n(600);
      check("R8 no pulse from flag write", npulse - base, 0);
      check("R8 flag readback", rd_data[2], 1'b1);

      // R4 software timeout flag starts countdown
      wr(8'h0A);
      wait_n(511);
      check("R4 rst_req early", rst_req, 1'b0);
      wait_n(1);
      check("R4 rst_req on time", rst_req, 1'b1);
      wr(8'h00);

      // R9 cancel by clearing reset enable
      base = npulse;
      wr(8'h0A);
      wait_n(100);
      wr(8'h48);
      wait_n(600);
      check("R9 cancel by enable clear", npulse - base, 0);
      check("R9 wdr flag stays clear", rd_data[2], 1'b0);
      wr(8'h00);

      // R9 cancel by restart bit (long interval avoids a new timeout)
      base = npulse;
      wr(8'h3A);
      wait_n(100);
      wr(8'h3B);
      wait_n(600);
      check("R9 cancel by restart", npulse - base, 0);
      check("R7 restart reads 0", rd_data[0], 1'b0);
      wr(8'h00);

      // R6 select change restarts interval
      wr(8'h41);
      wait_n(40);
      wr(8'h50);
      wait_n(511);
      check("R6 flag before new window", rd_data[3], 1'b0);
      wait_n(1);
      check("R6 flag at new window", rd_data[3], 1'b1);
      wr(8'h00);

      // R6 select change during countdown has no effect
      wr(8'h02);
      wait_n(64);
      check("R6 countdown started", rd_data[3], 1'b1);
      wait_n(100);
      wr(8'h1A);
      wait_n(410);
      check("R6 rst_req early", rst_req, 1'b0);
      wait_n(1);
      check("R6 rst_req unchanged timing", rst_req, 1'b1);
      wr(8'h00);

      // R7 restart postpones timeout
      wr(8'h41);
      wait_n(50);
      wr(8'h41);
      wait_n(63);
      check("R7 flag before window", rd_data[3], 1'b0);
      wait_n(1);
      check("R7 flag at window", rd_data[3], 1'b1);
      check("R2 irq with enable", irq, 1'b1);
      wr(8'h08);
      check("R2 irq after enable clear", irq, 1'b0);
      check("R5 flag kept", rd_data[3], 1'b1);

      // R10 power-on reset clears everything
      wr(8'h42);
      por_n = 1'b0;
      wait_n(1);
      por_n = 1'b1;
      check("R10 after power-on reset", rd_data, 8'h80);

      finish_run();
   end

endmodule